// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller of a five-stage in-order pipeline with fetch, decode/register read, execute, memory and write-back stages. From the register numbers held in the decode, execute, memory and write-back pipeline registers, it decides every cycle where each ALU operand of the execute-stage instruction comes from. The choices are the register-file value, the result held in the memory stage, or the result held in the write-back stage. The block also decides whether the pipeline front end must freeze for a load-use dependency, and whether the wrong-path instruction behind a mispredicted branch must be discarded.

Every instruction writes the register file only in stage 5, so there is never more than one write per cycle and no write-port arbitration is needed. The register file writes in the first half of a cycle and reads in the second half. A consumer three slots behind its producer therefore reads the new value directly, and no forwarding path from beyond write-back exists. Branches are predicted not taken. A misprediction squashes the single wrong-path instruction in the fetch/decode register.

A stall holds the PC and the fetch/decode register, and inserts a bubble into execute by clearing its control and valid bits. A small state machine ensures that a stall lasts exactly one cycle. It has two states. In ST_RUN a stall may be raised. ST_HOLD covers the cycle that follows a stall, when the bubble sits in execute. The transitions are:
- ST_RUN to ST_HOLD: a load-use hazard is found and no misprediction is present.
- ST_HOLD to ST_RUN: taken unconditionally on the next edge.
- ST_RUN to ST_RUN: no hazard is found, or a misprediction is present.
- Reset forces ST_RUN.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: An operand select is 1 (memory stage) when the memory-stage instruction writes, is not a load, and its destination equals the nonzero execute-stage source register.
- R2: An operand select is 2 (write-back stage) when the write-back instruction writes a destination equal to the nonzero source register and the memory stage does not qualify under R1. Otherwise the select is 0 (register file).
- R3: When both the memory stage and the write-back stage qualify, the select is 1, so the more recent producer wins.
- R4: A source register number of 0 always gives select 0.
- R5: A load in the memory stage is never a forwarding source. Its match falls through to the write-back stage or to select 0.
- R6: When the execute-stage instruction is a writing load with a nonzero destination equal to either decode source register, stall and bubble are both 1 in that same cycle. Stall and bubble are always equal.
- R7: A stall lasts at most one cycle. In the cycle after a stall, stall is 0 whatever the inputs.
- R8: Squash equals the mispredict input. While squash is 1, stall and bubble are 0 and no hold cycle follows.
- R9: While reset is low, stall, bubble and squash are 0, and the first cycle after reset may stall.
- R10: No stall is raised when the execute-stage instruction is not a load, does not write, or has destination 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_rs1 | input | REG_AW | First source register of the decode-stage instruction |
| id_rs2 | input | REG_AW | Second source register of the decode-stage instruction |
| ex_rs1 | input | REG_AW | First source register of the execute-stage instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute-stage instruction |
| ex_rd | input | REG_AW | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination register of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| br_mispredict | input | 1 | Branch resolved as taken against the not-taken guess |
| fwd_sel_a | output | 2 | Source select for ALU operand A (0 register file, 1 memory stage, 2 write-back) |
| fwd_sel_b | output | 2 | Source select for ALU operand B, same encoding |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Clear control and valid bits of the execute-stage register |
| squash | output | 1 | Clear the valid bit of the fetch/decode register |

## Verification
Directed cases separate the single-producer matches from a double match that exposes the priority order, and a match on register 0 shows that the zero guard works. A load sitting in the memory stage shows that a load value is not taken early. A load-use hazard held for several cycles tells a one-cycle stall apart from one that repeats, and a hazard coinciding with a mispredict shows which of the two wins. A long random run over a four-register space makes all producers collide often. In that run the outputs are compared each clock against a behavioural model.

// File: rtl/hz_pipe_pkg.sv
package hz_pipe_pkg;
    // Operand source encoding
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    // Stall control states
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } stall_st_e;

    localparam int NUM_OPND = 2;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0]     src_reg,
    input  logic [REG_AW-1:0]     mem_rd,
    input  logic                  mem_wr,
    input  logic                  mem_load,
    input  logic [REG_AW-1:0]     wb_rd,
    input  logic                  wb_wr,
    output hz_pipe_pkg::fwd_sel_e sel
);
    import hz_pipe_pkg::*;

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        src_live = |src_reg;
        // a load in the memory stage has no data yet
        mem_hit  = mem_wr && !mem_load && (mem_rd == src_reg);
        wb_hit   = wb_wr && (wb_rd == src_reg);
        sel      = FWD_RF;
        if (src_live && mem_hit) begin
            sel = FWD_MEM;
        end else if (src_live && wb_hit) begin
            sel = FWD_WB;
        end
    end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_wr,
    input  logic                           ex_load,
    output logic                           hit
);
    logic [NUM_SRC-1:0] src_match;
    logic               producer_ok;

    assign producer_ok = ex_load && ex_wr && (|ex_rd);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_match[s] = (id_src[s] == ex_rd);
    end

    assign hit = producer_ok && (|src_match);
endmodule

// File: rtl/hz_stall_fsm.sv
module hz_stall_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    input  logic mispredict,
    output logic stall,
    output logic bubble,
    output logic squash
);
    import hz_pipe_pkg::*;

    stall_st_e state_q;
    stall_st_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and next state
    always_comb begin
        stall   = 1'b0;
        bubble  = 1'b0;
        squash  = 1'b0;
        state_d = state_q;
        if (rst_n) begin
            unique case (state_q)
                ST_RUN: begin
                    if (mispredict) begin
                        squash = 1'b1;
                    end else if (hazard) begin
                        stall   = 1'b1;
                        bubble  = 1'b1;
                        state_d = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    squash  = mispredict;
                    state_d = ST_RUN;
                end
                default: state_d = ST_RUN;
            endcase
        end else begin
            state_d = ST_RUN;
        end
    end
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wr,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wr,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wr,
    input  logic              br_mispredict,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              stall,
    output logic              bubble,
    output logic              squash
);
    import hz_pipe_pkg::*;

    logic [NUM_OPND-1:0][REG_AW-1:0] id_src;
    logic [NUM_OPND-1:0][REG_AW-1:0] ex_src;
    fwd_sel_e                        opnd_sel [NUM_OPND];
    logic                            lu_hit;

    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;
    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        hz_fwd_pick #(.REG_AW(REG_AW)) pick_i (
            .src_reg  (ex_src[k]),
            .mem_rd   (mem_rd),
            .mem_wr   (mem_wr),
            .mem_load (mem_load),
            .wb_rd    (wb_rd),
            .wb_wr    (wb_wr),
            .sel      (opnd_sel[k])
        );
    end

    assign fwd_sel_a = opnd_sel[0];
    assign fwd_sel_b = opnd_sel[1];

    hz_loaduse_det #(.REG_AW(REG_AW), .NUM_SRC(NUM_OPND)) det_i (
        .id_src  (id_src),
        .ex_rd   (ex_rd),
        .ex_wr   (ex_wr),
        .ex_load (ex_load),
        .hit     (lu_hit)
    );

    hz_stall_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hazard     (lu_hit),
        .mispredict (br_mispredict),
        .stall      (stall),
        .bubble     (bubble),
        .squash     (squash)
    );
endmodule

// File: rtl/hz_pipe_ctrl_chk.sv
module hz_pipe_ctrl_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rs2,
    input logic              ex_load,
    input logic              mem_load,
    input logic              br_mispredict,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              stall,
    input logic              bubble,
    input logic              squash
);
    AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (fwd_sel_a == 2'd0)); // R4
    AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs2 == '0) |-> (fwd_sel_b == 2'd0)); // R4
    AST_LOAD_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_load |-> (fwd_sel_a != 2'd1 && fwd_sel_b != 2'd1)); // R5
    AST_BUBBLE_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bubble == stall); // R6
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R7
    AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (!stall && !bubble)); // R8
    AST_SQUASH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        squash == br_mispredict); // R8
    AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !stall); // R10
endmodule

bind hz_pipe_ctrl hz_pipe_ctrl_chk #(.REG_AW(REG_AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ex_rs1        (ex_rs1),
    .ex_rs2        (ex_rs2),
    .ex_load       (ex_load),
    .mem_load      (mem_load),
    .br_mispredict (br_mispredict),
    .fwd_sel_a     (fwd_sel_a),
    .fwd_sel_b     (fwd_sel_b),
    .stall         (stall),
    .bubble        (bubble),
    .squash        (squash)
);

// File: tb/hz_pipe_ctrl_tb_top.sv
module hz_pipe_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic [AW-1:0] mem_rd = '0, wb_rd = '0;
    logic          ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, mem_load = 1'b0;
    logic          wb_wr = 1'b0, br_mispredict = 1'b0;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          stall, bubble, squash;

    int  checks = 0;
    int  errors = 0;
    bit  held = 1'b0;
    bit  done = 1'b0;

    hz_pipe_ctrl #(.REG_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wr(ex_wr),
        .ex_load(ex_load), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_load(mem_load),
        .wb_rd(wb_rd), .wb_wr(wb_wr), .br_mispredict(br_mispredict),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .stall(stall),
        .bubble(bubble), .squash(squash)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    function automatic int ref_sel(input int src);
        if (src == 0) return 0;
        if (mem_wr && !mem_load && int'(mem_rd) == src) return 1;
        if (wb_wr && int'(wb_rd) == src) return 2;
        return 0;
    endfunction

    function automatic string sel_tag(input int src);
        bit m_any = mem_wr && int'(mem_rd) == src;
        bit w_any = wb_wr && int'(wb_rd) == src;
        if (src == 0) return "R4";
        if (m_any && mem_load) return "R5";
        if (m_any && w_any) return "R3";
        if (m_any) return "R1";
        return "R2";
    endfunction

    function automatic bit ref_hazard();
        return ex_load && ex_wr && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    function automatic bit ref_stall();
        return rst_n && !held && !br_mispredict && ref_hazard();
    endfunction

    function automatic string stall_tag();
        if (!rst_n) return "R9";
        if (br_mispredict) return "R8";
        if (held) return "R7";
        if (ref_hazard()) return "R6";
        return "R10";
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) held <= 1'b0;
        else        held <= ref_stall();
    end

    always @(negedge clk) begin
        if (!done) begin
            cmp(sel_tag(int'(ex_rs1)), "fwd_sel_a", int'(fwd_sel_a), ref_sel(int'(ex_rs1)));
            cmp(sel_tag(int'(ex_rs2)), "fwd_sel_b", int'(fwd_sel_b), ref_sel(int'(ex_rs2)));
            cmp(stall_tag(), "stall", int'(stall), int'(ref_stall()));
            cmp(stall_tag(), "bubble", int'(bubble), int'(ref_stall()));
            cmp(rst_n ? "R8" : "R9", "squash", int'(squash), int'(rst_n && br_mispredict));
        end
    end

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
        ex_wr = 0; ex_load = 0; mem_rd = '0; mem_wr = 0; mem_load = 0;
        wb_rd = '0; wb_wr = 0; br_mispredict = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R9: reset with a hazard and a mispredict present
        ex_load = 1; ex_wr = 1; ex_rd = 5'd7; id_rs1 = 5'd7; br_mispredict = 1;
        nxt(); nxt(); nxt();
        clear_in();
        rst_n = 1;
        nxt();
        // R1: memory-stage producer
        ex_rs1 = 5'd3; mem_rd = 5'd3; mem_wr = 1; nxt();
        // R2: write-back producer on operand B
        clear_in(); ex_rs2 = 5'd4; wb_rd = 5'd4; wb_wr = 1; nxt();
        // R3: both producers match
        clear_in(); ex_rs1 = 5'd5; ex_rs2 = 5'd5; mem_rd = 5'd5; mem_wr = 1;
        wb_rd = 5'd5; wb_wr = 1; nxt();
        // R4: register 0 with matching producers
        clear_in(); mem_wr = 1; wb_wr = 1; nxt();
        // R5: load in memory stage, with and without write-back match
        clear_in(); ex_rs1 = 5'd9; mem_rd = 5'd9; mem_wr = 1; mem_load = 1;
        wb_rd = 5'd9; wb_wr = 1; nxt();
        wb_wr = 0; nxt();
        // R6, R7: hazard held for three cycles stalls, releases, stalls
        clear_in(); ex_load = 1; ex_wr = 1; ex_rd = 5'd6; id_rs2 = 5'd6;
        nxt(); nxt(); nxt();
        // R8: mispredict together with hazard
        br_mispredict = 1; nxt(); nxt();
        // R10: non-writing load, destination 0, non-load
        clear_in(); ex_load = 1; ex_rd = 5'd2; id_rs1 = 5'd2; nxt();
        ex_wr = 1; ex_rd = '0; id_rs1 = '0; nxt();
        ex_load = 0; ex_rd = 5'd2; id_rs1 = 5'd2; nxt();
        // R9: reset mid-stall
        clear_in(); ex_load = 1; ex_wr = 1; ex_rd = 5'd1; id_rs1 = 5'd1; nxt();
        rst_n = 0; nxt();
        rst_n = 1; nxt(); nxt();
        // random collisions over a small register space
        for (int i = 0; i < 3000; i++) begin
            id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
            ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
            ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
            wb_rd = AW'($urandom_range(0, 3));
            ex_wr = 1'($urandom); ex_load = 1'($urandom); mem_wr = 1'($urandom);
            mem_load = 1'($urandom); wb_wr = 1'($urandom);
            br_mispredict = ($urandom_range(0, 7) == 0);
            nxt();
        end
        @(negedge clk);
        #1;
        finish_run();
    end
endmodule